// File: doc/BRIEF.md
# Two-Pass Vector Range Normalizer

This block takes a vector of wide unsigned fixed-point values and rescales it into a narrow output width. The wide values come from an earlier arithmetic stage whose intermediate results were kept at full precision. A product of two n-bit operands needs 2n bits. A sum of m n-bit terms needs n + ceil(log2 m) bits. Each producing stage therefore gets its own instance, with the input width set by elaboration parameters.

Processing takes two passes over the vector.
- **First pass.** The vector is streamed in and stored locally. A comparator tracks the smallest and the largest element.
- **Second pass.** Each stored element is read back in arrival order. Its distance from the minimum is multiplied by a desired maximum, and the product is divided by the span (maximum minus minimum) in an iterative divider. The quotient is truncated to the output width.

A vector whose elements are all equal has a span of zero. Such a vector is flagged as degenerate, and every one of its outputs is zero. Both element streams use valid/ready handshakes. Back-pressure on the output stalls the second pass.

Top module: `vrange_norm`

## Requirements
- R1: While reset is asserted and just after it is released, `in_ready` is 1, `out_valid` is 0 and `degenerate` is 0.
- R2: The first pass accepts exactly VLEN elements, with `in_ready` high. From the last acceptance until the last output handshake of the second pass, `in_ready` is 0. After that last output handshake, `in_ready` is 1 again.
- R3: Each output equals floor((x - min) * D / (max - min)), where:
  - x is the element, treated as unsigned;
  - min and max are the extremes of the whole vector;
  - D is the latched desired maximum.
- R4: The second pass emits exactly VLEN outputs, in the same order the elements arrived. After the last output, `out_valid` stays 0.
- R5: An element equal to the vector minimum produces 0. An element equal to the vector maximum produces D.
- R6: When max equals min:
  - every output of that vector is 0;
  - `degenerate` is 1 for that vector's whole second pass;
  - `degenerate` is 0 once the first element of the next vector has been accepted, and 0 during any non-degenerate second pass.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R8: `des_max` is sampled when the last element of the first pass is accepted. Later changes to `des_max` have no effect on that vector's outputs.
- R9: An output never exceeds the latched desired maximum.
- R10: Elements up to the full input width (2^IN_W - 1) are rescaled correctly, with no overflow in the product or the span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block accepts an input element (first pass) |
| in_data | input | IN_W | Wide unsigned input element |
| des_max | input | OUT_W | Desired maximum of the output range |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer accepts an output element |
| out_data | output | OUT_W | Rescaled output element |
| degenerate | output | 1 | Current vector has zero span |

## Verification
The hardest situations to reach from the ports are a change of `des_max` after the first pass has closed, and a long output stall that lands while a quotient is being held.

The stimulus gets there as follows:
- `des_max` is rewritten between the last input handshake and the first output. All outputs must still follow the old value.
- `out_ready` is held low for several cycles on every element of one vector, and the held data is compared cycle by cycle.
- A constant vector forces the zero-span path.
- A ramp that ends at the top of the input range drives the widest product and span.

// File: rtl/vnorm_pkg.sv
package vnorm_pkg;
  typedef enum logic [2:0] {
    ST_LOAD  = 3'd0,
    ST_PREP  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_SEND  = 3'd4
  } vn_state_e;
endpackage

// File: rtl/vnorm_store.sv
module vnorm_store #(
  parameter int DEPTH = 16,
  parameter int W     = 20,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/vnorm_extreme.sv
module vnorm_extreme #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         first,
  input  logic [W-1:0] din,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic         seen_q, seen_d;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    seen_d = seen_q;
    if (upd_en) begin
      seen_d = 1'b1;
      if (first) begin
        lo_d = din;
        hi_d = din;
      end else begin
        if (din < lo_q) lo_d = din;
        if (din > hi_q) hi_d = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      seen_q <= seen_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;

  AST_EXTREME_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (lo_q <= hi_q)); // R3

  AST_EXTREME_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !first && seen_q) |=> (lo_q <= $past(din)) && (hi_q >= $past(din))); // R5
endmodule

// File: rtl/vnorm_divider.sv
module vnorm_divider #(
  parameter int NW = 28,
  parameter int DW = 20,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quo
);
  logic [DW:0]   rem_q, rem_d;
  logic [NW-1:0] q_q, q_d;
  logic [DW-1:0] den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic [DW:0]   rem_sh;
  logic          fits;

  assign rem_sh = {rem_q[DW-1:0], q_q[NW-1]};
  assign fits   = (rem_sh >= {1'b0, den_q});

  always_comb begin
    rem_d  = rem_q;
    q_d    = q_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      rem_d  = '0;
      q_d    = num;
      den_d  = den;
      cnt_d  = CW'(NW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
      q_d   = {q_q[NW-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      q_q    <= q_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = q_q;

  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R3

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < {1'b0, den_q})); // R10
endmodule

// File: rtl/vrange_norm.sv
module vrange_norm
  import vnorm_pkg::*;
#(
  parameter int VLEN  = 16,
  parameter int IN_W  = 20,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic [OUT_W-1:0] des_max,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             degenerate
);
  localparam int IDX_W = (VLEN > 1) ? $clog2(VLEN) : 1;
  localparam int NW    = IN_W + OUT_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VLEN - 1);

  vn_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [OUT_W-1:0] dmax_q, dmax_d;
  logic [OUT_W-1:0] out_q, out_d;
  logic             degen_q, degen_d;

  logic             accept, oshake;
  logic [IN_W-1:0]  rd_elem, lo, hi;
  logic [IN_W-1:0]  span, offs;
  logic [NW-1:0]    numer;
  logic             div_start, div_busy, div_done;
  logic [NW-1:0]    div_quo;

  assign in_ready  = (state_q == ST_LOAD);
  assign out_valid = (state_q == ST_SEND);
  assign accept    = in_valid && in_ready;
  assign oshake    = out_valid && out_ready;

  vnorm_store #(.DEPTH(VLEN), .W(IN_W)) store_i (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (idx_q),
    .wr_data (in_data),
    .rd_addr (idx_q),
    .rd_data (rd_elem)
  );

  vnorm_extreme #(.W(IN_W)) ext_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (accept),
    .first  (idx_q == '0),
    .din    (in_data),
    .lo     (lo),
    .hi     (hi)
  );

  assign span      = hi - lo;
  assign offs      = rd_elem - lo;
  assign numer     = NW'(offs) * NW'(dmax_q);
  assign div_start = (state_q == ST_ISSUE) && !degen_q;

  vnorm_divider #(.NW(NW), .DW(IN_W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (numer),
    .den   (span),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    dmax_d  = dmax_q;
    out_d   = out_q;
    degen_d = degen_q;
    unique case (state_q)
      ST_LOAD: begin
        if (accept) begin
          if (idx_q == '0) degen_d = 1'b0;
          if (idx_q == LAST_IDX) begin
            idx_d   = '0;
            dmax_d  = des_max;
            state_d = ST_PREP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_PREP: begin
        degen_d = (span == '0);
        state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (degen_q) begin
          out_d   = '0;
          state_d = ST_SEND;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (div_done) begin
          out_d   = div_quo[OUT_W-1:0];
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (oshake) begin
          if (idx_q == LAST_IDX) begin
            idx_d   = '0;
            state_d = ST_LOAD;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      idx_q   <= '0;
      dmax_q  <= '0;
      out_q   <= '0;
      degen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dmax_q  <= dmax_d;
      out_q   <= out_d;
      degen_q <= degen_d;
    end
  end

  assign out_data   = out_q;
  assign degenerate = degen_q;

  AST_OUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= dmax_q)); // R9

  AST_QUO_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (div_quo <= NW'(dmax_q))); // R9

  AST_DEGEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && degenerate) |-> (out_data == '0)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_PASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R2

  AST_DMAX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !$rose(out_valid) && $past(!in_ready)) |-> $stable(dmax_q)); // R8

  AST_DIV_IDLE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !div_busy); // R3
endmodule

// File: tb/vrange_norm_tb.sv
module vrange_norm_tb_top;
  localparam int  VLEN    = 16;
  localparam int  IN_W    = 20;
  localparam int  OUT_W   = 8;
  localparam time CLK_PER = 10ns;
  localparam int  NTAB    = 6;

  // table entry: kind(2) | base(20) | step(20) | dmax(8)
  // kind 0 ascending ramp, 1 descending ramp, 2 scrambled (k*5 mod VLEN), 3 constant
  localparam logic [49:0] TAB [NTAB] = '{
    {2'd0, 20'd100,     20'd37,   8'd255},
    {2'd1, 20'd5000,    20'd300,  8'd200},
    {2'd2, 20'd0,       20'd4099, 8'd99},
    {2'd3, 20'd777,     20'd0,    8'd255},
    {2'd0, 20'd1033575, 20'd1000, 8'd255},
    {2'd2, 20'd12,      20'd1,    8'd7}
  };

  logic             clk, rst_n;
  logic             in_valid, in_ready, out_valid, out_ready, degenerate;
  logic [IN_W-1:0]  in_data;
  logic [OUT_W-1:0] des_max, out_data;

  int nchk  = 0;
  int nfail = 0;
  logic [IN_W-1:0] vec [VLEN];

  vrange_norm #(.VLEN(VLEN), .IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .des_max    (des_max),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .degenerate (degenerate)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint gen(input int kind, input longint base, input longint step, input int k);
    case (kind)
      0:       return base + k * step;
      1:       return base + (VLEN - 1 - k) * step;
      2:       return base + ((k * 5) % VLEN) * step;
      default: return base;
    endcase
  endfunction

  // Feeds vec, then collects VLEN outputs and compares with expected values
  task automatic run_vec(input logic [OUT_W-1:0] dm, input bit stall, input bit chg_dm, input string req);
    longint mn, mx, x, exp;
    logic [OUT_W-1:0] got;
    bit degen;
    mn = vec[0]; mx = vec[0];
    for (int k = 1; k < VLEN; k++) begin
      if (vec[k] < mn) mn = vec[k];
      if (vec[k] > mx) mx = vec[k];
    end
    degen   = (mn == mx);
    des_max = dm;
    for (int k = 0; k < VLEN; k++) begin
      in_data  = vec[k];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (k == 0) chk("R6 flag cleared on first accept", degenerate, 0);
    end
    in_valid = 1'b0;
    chk("R2 in_ready low after pass 1", in_ready, 0);
    if (chg_dm) des_max = ~dm;
    for (int k = 0; k < VLEN; k++) begin
      out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      got = out_data;
      if (stall) begin
        repeat (3) @(negedge clk);
        chk("R7 valid held", out_valid, 1);
        chk("R7 data held", out_data, got);
      end
      x   = vec[k];
      exp = degen ? 0 : ((x - mn) * dm) / (mx - mn);
      if (degen)                   chk("R6 zero output", out_data, 0);
      else if (x == mn || x == mx) chk("R5 extreme mapping", out_data, exp);
      else                         chk(req, out_data, exp);
      chk("R6 flag level", degenerate, degen);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk("R4 no extra output", out_valid, 0);
    chk("R2 in_ready back high", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; des_max = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", in_ready, 1);
    chk("R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 degenerate after reset", degenerate, 0);

    for (int t = 0; t < NTAB; t++) begin
      for (int k = 0; k < VLEN; k++)
        vec[k] = IN_W'(gen(int'(TAB[t][49:48]), longint'(TAB[t][47:28]), longint'(TAB[t][27:8]), k));
      run_vec(TAB[t][7:0], 1'b0, 1'b0, (t == 4) ? "R10 full width" : "R3 rescale");
    end

    // back-pressure on every element, scrambled order (R7, R4)
    for (int k = 0; k < VLEN; k++) vec[k] = IN_W'(gen(2, 300, 911, k));
    run_vec(8'd180, 1'b1, 1'b0, "R4 ordered under stall");

    // desired maximum rewritten after pass 1 (R8)
    for (int k = 0; k < VLEN; k++) vec[k] = IN_W'(gen(1, 40, 2500, k));
    run_vec(8'd150, 1'b0, 1'b1, "R8 latched desired max");

    // degenerate vector followed by a normal one (R6)
    for (int k = 0; k < VLEN; k++) vec[k] = IN_W'(20'hFFFFF);
    run_vec(8'd255, 1'b1, 1'b0, "R6 constant top value");
    for (int k = 0; k < VLEN; k++) vec[k] = IN_W'(gen(0, 0, 65535, k));
    run_vec(8'd255, 1'b0, 1'b0, "R3 after degenerate");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule